// File: doc/BRIEF.md
# Endian-Configurable Load/Store Aligner

This block connects a 64-bit register datapath to a byte-addressed memory port that is eight bytes wide. A store request of one, two, four or eight bytes is turned into a byte-enable mask and a write doubleword in which the register value has been steered into the right byte lanes. A load request records where its bytes sit. When the memory returns the doubleword, the block picks those bytes out and sign- or zero-extends them to a full 64-bit result.

A run-time mode input chooses the byte order. In little-endian order the least significant byte of a value sits at the lowest address. In big-endian order the most significant byte sits there. Every access must be naturally aligned. A request whose address is not a multiple of its size is not performed: the block raises a fault flag for one cycle instead. Only one load may be in flight at a time, and memory returns its data at least one cycle after the load request.

Top module: `ldst_aligner`

## Requirements
- R1: A valid request whose address bits [2:0] are not a multiple of the access size raises `fault` for exactly the next cycle. During the request cycle that request drives no byte enable, `mem_we` or `mem_rd`.
- R2: An aligned store of n bytes (size code 0/1/2/3 means n = 1/2/4/8) drives `mem_be` with exactly n contiguous ones, starting at bit `addr[2:0]`. Bit k of `mem_be` enables memory lane k, which is `mem_wdata[8k+7:8k]` and holds the byte at doubleword address + k.
- R3: In little-endian mode (`big_endian`=0), byte i of the store value (i=0 is least significant) appears in lane `addr[2:0]`+i.
- R4: In big-endian mode (`big_endian`=1), byte i of the store value appears in lane `addr[2:0]`+n-1-i.
- R5: For stores narrower than 8 bytes, the n-byte lane pattern is replicated into every n-byte group of `mem_wdata`.
- R6: In little-endian mode, byte j of the load result is taken from memory lane offset+j, where offset is bits [2:0] of the load address.
- R7: In big-endian mode, byte j of the load result is taken from memory lane offset+n-1-j.
- R8: A signed load (`req_unsigned`=0) fills result bits 63 down to 8n with the most significant loaded bit.
- R9: An unsigned load (`req_unsigned`=1) fills result bits 63 down to 8n with zeros.
- R10: `ld_valid` is high exactly in the cycle after each `mem_rvalid`, with `ld_data` registered alongside it.
- R11: While `rst` is high and in the first cycle after it, `fault` and `ld_valid` are low.
- R12: `mem_we` is high only for an aligned valid store and `mem_rd` only for an aligned valid load. No byte enable is driven for loads or idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Byte-order mode: 1 big-endian, 0 little-endian |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_unsigned | input | 1 | Load zero-extends when 1 |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 doubleword |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 64 | Store value, right-justified |
| mem_we | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_be | output | 8 | Byte-lane write enables |
| mem_wdata | output | 64 | Lane-steered, replicated write doubleword |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 64 | Memory read doubleword |
| fault | output | 1 | One-cycle misalignment fault |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended load result |

## Verification
Stores and loads are run at every size, at every aligned offset within the doubleword, and in both byte orders. Because each load uses data with distinct bytes in every lane, a wrong lane choice or a reversed byte order shows up as a different value. Loads are tried with the top loaded bit both set and clear, in signed and unsigned form, which separates the sign fill from the zero fill. Misaligned addresses for each size larger than a byte show that the fault appears with nothing driven to memory. A long randomized stretch then mixes all of these with idle cycles.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int DATA_W = 64;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [OFF_W-1:0] offset;
        acc_size_e        size;
        logic             zext;
        logic             big;
    } ld_ctx_t;

    function automatic logic [OFF_W:0] size_bytes(acc_size_e s);
        return (OFF_W+1)'(1) << s;
    endfunction

    function automatic logic off_bad(logic [OFF_W-1:0] off, acc_size_e s);
        logic [OFF_W:0] m;
        m = size_bytes(s) - (OFF_W+1)'(1);
        return ({1'b0, off} & m) != '0;
    endfunction

endpackage

// File: rtl/ldst_align_chk.sv
module ldst_align_chk
    import ldst_pkg::*;
(
    input  logic             valid,
    input  logic             store,
    input  logic [OFF_W-1:0] offset,
    input  acc_size_e        size,
    output logic             bad,
    output logic             wr_ok,
    output logic             rd_ok
);
    logic misal;

    always_comb begin
        misal = off_bad(offset, size);
        bad   = valid && misal;
        wr_ok = valid && !misal && store;
        rd_ok = valid && !misal && !store;
    end
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
    import ldst_pkg::*;
(
    input  logic              en,
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    input  logic              big,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] data
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [OFF_W:0] KL = (OFF_W+1)'(k);
        logic [OFF_W:0] n, pos, src, grp;

        always_comb begin
            n   = size_bytes(size);
            pos = KL & (n - (OFF_W+1)'(1));
            src = big ? (n - (OFF_W+1)'(1) - pos) : pos;
            grp = KL & ~(n - (OFF_W+1)'(1));
            data[8*k +: 8] = wdata[{src[OFF_W-1:0], 3'b000} +: 8];
            be[k] = en && (grp[OFF_W-1:0] == offset);
        end
    end
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
    import ldst_pkg::*;
(
    input  ld_ctx_t           ctx,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);
    logic [OFF_W:0]   n;
    logic [OFF_W-1:0] top_lane;
    logic             sbit;
    logic [7:0]       fill;

    always_comb begin
        n        = size_bytes(ctx.size);
        top_lane = ctx.offset + (ctx.big ? '0 : OFF_W'(n - (OFF_W+1)'(1)));
        sbit     = rdata[{top_lane, 3'b111}];
        fill     = ctx.zext ? 8'h00 : {8{sbit}};
    end

    for (genvar j = 0; j < LANES; j++) begin : g_byte
        localparam logic [OFF_W:0] JL = (OFF_W+1)'(j);
        logic [OFF_W:0]   sel;
        logic [OFF_W-1:0] lane;

        always_comb begin
            sel  = ctx.big ? (n - (OFF_W+1)'(1) - JL) : JL;
            lane = ctx.offset + sel[OFF_W-1:0];
            value[8*j +: 8] = (JL < n) ? rdata[{lane, 3'b000} +: 8] : fill;
        end
    end
endmodule

// File: rtl/ldst_aligner.sv
module ldst_aligner
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_endian,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_unsigned,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              mem_we,
    output logic              mem_rd,
    output logic [7:0]        mem_be,
    output logic [63:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              fault,
    output logic              ld_valid,
    output logic [63:0]       ld_data
);
    acc_size_e        size;
    logic [OFF_W-1:0] offset;
    logic             bad, wr_ok, rd_ok;
    ld_ctx_t          ctx_q;
    logic [63:0]      ext_value;

    assign size   = acc_size_e'(req_size);
    assign offset = req_addr[OFF_W-1:0];

    ldst_align_chk u_align (
        .valid  (req_valid),
        .store  (req_store),
        .offset (offset),
        .size   (size),
        .bad    (bad),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok)
    );

    ldst_store_lanes u_store (
        .en     (wr_ok),
        .offset (offset),
        .size   (size),
        .big    (big_endian),
        .wdata  (req_wdata),
        .be     (mem_be),
        .data   (mem_wdata)
    );

    ldst_load_extract u_load (
        .ctx    (ctx_q),
        .rdata  (mem_rdata),
        .value  (ext_value)
    );

    assign mem_we = wr_ok;
    assign mem_rd = rd_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault    <= 1'b0;
            ld_valid <= 1'b0;
            ld_data  <= '0;
            ctx_q    <= '0;
        end else begin
            fault    <= bad;
            ld_valid <= mem_rvalid;
            if (mem_rvalid) ld_data <= ext_value;
            if (rd_ok) begin
                ctx_q.offset <= offset;
                ctx_q.size   <= size;
                ctx_q.zext   <= req_unsigned;
                ctx_q.big    <= big_endian;
            end
        end
    end
endmodule

// File: rtl/ldst_aligner_chk.sv
module ldst_aligner_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_store,
    input logic [1:0] req_size,
    input logic       mem_we,
    input logic       mem_rd,
    input logic [7:0] mem_be,
    input logic       mem_rvalid,
    input logic       fault,
    input logic       ld_valid
);
    AST_FAULT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(req_valid)) else $error("fault without request"); // R1
    AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($past(mem_be) == 8'h00 && !$past(mem_we) && !$past(mem_rd))) else $error("faulted access driven"); // R1
    AST_BE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (mem_be != 8'h00) |-> ($countones(mem_be) == (1 << req_size))) else $error("byte enable count"); // R2
    AST_BE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
        (mem_be != 8'h00) |-> (req_valid && req_store && mem_we)) else $error("byte enable outside store"); // R12
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_rd)) else $error("read and write together"); // R12
    AST_LD_AFTER_RVALID: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |=> ld_valid) else $error("missing load result"); // R10
    AST_LD_ONLY_AFTER_RVALID: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(mem_rvalid)) else $error("spurious load result"); // R10
endmodule

bind ldst_aligner ldst_aligner_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .mem_we     (mem_we),
    .mem_rd     (mem_rd),
    .mem_be     (mem_be),
    .mem_rvalid (mem_rvalid),
    .fault      (fault),
    .ld_valid   (ld_valid)
);

// File: tb/test_ldst_aligner.sv
`timescale 1ns/1ps
module test_ldst_aligner;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          big_endian, req_valid, req_store, req_unsigned;
    logic [1:0]    req_size;
    logic [AW-1:0] req_addr;
    logic [63:0]   req_wdata;
    logic          mem_we, mem_rd;
    logic [7:0]    mem_be;
    logic [63:0]   mem_wdata;
    logic          mem_rvalid;
    logic [63:0]   mem_rdata;
    logic          fault, ld_valid;
    logic [63:0]   ld_data;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit          m_fault, m_ldv;
    logic [63:0] m_ldd;
    int          c_off, c_n;
    bit          c_uns, c_big;

    always #4 clk = ~clk;

    ldst_aligner #(.ADDR_W(AW)) i_ldst_aligner (
        .clk(clk), .rst(rst), .big_endian(big_endian),
        .req_valid(req_valid), .req_store(req_store), .req_unsigned(req_unsigned),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_we(mem_we), .mem_rd(mem_rd), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fault(fault), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] nmask(int n);
        return (n == 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
    endfunction

    function automatic logic [63:0] rev_bytes(logic [63:0] v, int n);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] ref_wdata(logic [63:0] d, int n, bit big);
        logic [63:0] v = d & nmask(n);
        logic [63:0] r = '0;
        if (big) v = rev_bytes(v, n);
        for (int g = 0; g < 8 / n; g++) r |= v << (8*n*g);
        return r;
    endfunction

    function automatic logic [63:0] ref_load(logic [63:0] d, int off, int n, bit big, bit uns);
        logic [63:0] v = (d >> (8*off)) & nmask(n);
        if (big) v = rev_bytes(v, n);
        if (!uns && v[8*n-1]) v |= ~nmask(n);
        return v;
    endfunction

    // one cycle: drive at negedge, check combinational outputs, then registered ones
    task automatic step(bit v, bit st, bit uns, int sz, logic [AW-1:0] a,
                        logic [63:0] wd, bit rv, logic [63:0] rd);
        int  n   = 1 << sz;
        int  off = int'(a[2:0]);
        bit  bad = v && (off % n != 0);
        logic [7:0] be_exp;
        string tg;
        @(negedge clk);
        req_valid = v; req_store = st; req_unsigned = uns; req_size = 2'(sz);
        req_addr = a; req_wdata = wd; mem_rvalid = rv; mem_rdata = rd;
        #1;
        be_exp = (v && st && !bad) ? 8'(((1 << n) - 1) << off) : 8'h00;
        check(bad ? "R1 be" : "R2 be", 64'(mem_be), 64'(be_exp));
        check("R12 we", 64'(mem_we), 64'(v && st && !bad));
        check("R12 rd", 64'(mem_rd), 64'(v && !st && !bad));
        if (v && st && !bad) begin
            tg = big_endian ? "R4 wdata" : "R3 wdata";
            check(tg, mem_wdata, ref_wdata(wd, n, big_endian));
            if (n < 8) check("R5 replicate", 64'(mem_wdata[63:32]), 64'(mem_wdata[31:0]));
        end
        // model update at the edge
        m_fault = bad;
        m_ldv   = rv;
        if (rv) m_ldd = ref_load(rd, c_off, c_n, c_big, c_uns);
        @(posedge clk);
        #1;
        check("R1 fault", 64'(fault), 64'(m_fault));
        check("R10 ld_valid", 64'(ld_valid), 64'(m_ldv));
        if (m_ldv) begin
            if (c_uns)                      tg = "R9 zext";
            else if (m_ldd[63] && c_n < 8)  tg = "R8 sext";
            else if (c_big)                 tg = "R7 load";
            else                            tg = "R6 load";
            check(tg, ld_data, m_ldd);
        end
        if (v && !st && !bad) begin
            c_off = off; c_n = n; c_uns = uns; c_big = big_endian;
        end
    endtask

    task automatic do_load(bit uns, int sz, logic [AW-1:0] a, logic [63:0] rd);
        step(1, 0, uns, sz, a, '0, 0, '0);
        step(0, 0, 0, 0, '0, '0, 1, rd);
        step(0, 0, 0, 0, '0, '0, 0, '0);
    endtask

    initial begin
        #(8*200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; big_endian = 0; req_valid = 0; req_store = 0; req_unsigned = 0;
        req_size = 0; req_addr = '0; req_wdata = '0; mem_rvalid = 0; mem_rdata = '0;
        m_ldd = '0; c_off = 0; c_n = 1; c_uns = 0; c_big = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R11 fault in reset", 64'(fault), 64'(0));
        check("R11 ld_valid in reset", 64'(ld_valid), 64'(0));
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R11 fault after reset", 64'(fault), 64'(0));
        check("R11 ld_valid after reset", 64'(ld_valid), 64'(0));

        // directed stores: every size, offset and byte order
        for (int b = 0; b < 2; b++) begin
            big_endian = b[0];
            for (int sz = 0; sz < 4; sz++)
                for (int o = 0; o < 8; o += (1 << sz))
                    step(1, 1, 0, sz, AW'(32'h100 + o), 64'h8877_6655_4433_2211, 0, '0);
        end
        // directed loads with distinct lane bytes, negative and positive tops
        for (int b = 0; b < 2; b++) begin
            big_endian = b[0];
            for (int sz = 0; sz < 4; sz++)
                for (int o = 0; o < 8; o += (1 << sz)) begin
                    do_load(0, sz, AW'(32'h200 + o), 64'hF7E6_D5C4_B3A2_9180);
                    do_load(1, sz, AW'(32'h200 + o), 64'hF7E6_D5C4_B3A2_9180);
                    do_load(0, sz, AW'(32'h200 + o), 64'h7766_5544_3322_1100);
                end
        end
        // misaligned requests of every size above a byte
        for (int sz = 1; sz < 4; sz++) begin
            step(1, 1, 0, sz, AW'(32'h301), 64'h1234, 0, '0);
            step(1, 0, 0, sz, AW'(32'h303), '0, 0, '0);
            step(0, 0, 0, 0, '0, '0, 0, '0);
        end
        // randomized mix
        for (int i = 0; i < 600; i++) begin
            int          sz = $urandom_range(3);
            logic [AW-1:0] a = AW'($urandom);
            logic [63:0] d = {$urandom, $urandom};
            big_endian = 1'($urandom);
            if ($urandom_range(1)) a[2:0] = a[2:0] & ~3'((1 << sz) - 1);
            case ($urandom_range(3))
                0: step(1, 1, 0, sz, a, d, 0, '0);
                1: do_load(1'($urandom), sz, a, d);
                2: step(1, 0, 0, sz, a, '0, 0, '0);
                default: step(0, 0, 0, 0, '0, '0, 0, '0);
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule